// File: doc/BRIEF.md
# Real-Time Counter with Match Alarm

This is a memory-mapped seconds counter with one compare register and one maskable alarm interrupt. A free-running counter of parameter width advances by one on each clock cycle in which the tick enable is high. The tick enable normally pulses once per second. The counter wraps to zero after its maximum value. Software can preset the counter through a load register and program an alarm value. When the counter and the alarm value become equal, a sticky raw status bit is set. A one-bit mask decides whether that status drives the level interrupt output.

The equality is evaluated whenever the count or the alarm value changes. This covers a tick, a load write and a match write. Writing an alarm value equal to the present count raises the status at once. The interrupt output and the masked status read back from the same pair of state bits.

The register port is a simple slave. It has a 12-bit byte address, a write strobe, write data and combinational read data. Registers are selected by word address, so address bits [1:0] are ignored. A window of eight identification bytes sits at the top of the 4 KB region.

Top module: `rtc_match_timer`

## Requirements
- R1: After reset, the counter, alarm value, load value, mask and raw status all read 0, and `irq_o` is low.
- R2: Each cycle with `tick_i` high increments the counter, which wraps from all ones to 0. With `tick_i` low and no load write, the counter holds its value.
- R3: A write to offset 0x08 sets the counter to the written value on the next edge, with priority over a tick in the same cycle. Offset 0x08 reads back the last value loaded, and offset 0x00 reads the current count.
- R4: A write to offset 0x04 stores the alarm value, which reads back at 0x04. If the written value equals the count at that edge, the raw status is set at once.
- R5: When a tick makes the counter equal to the alarm value, the raw status is set, including across wraparound. It stays set while the counter moves on.
- R6: Offset 0x10 holds a mask of bit 0 only. `irq_o` and bit 0 of offset 0x18 both equal raw status AND mask, and both follow a mask write on the next edge.
- R7: Any write to offset 0x1C clears the raw status, whatever the data. If an alarm hit occurs in the same cycle, the set wins.
- R8: Offset 0x0C always reads 1, and writes to it have no effect.
- R9: Offsets 0xFE0 to 0xFFF return identification byte number addr[4:2] of parameter `ID_VALUE` (byte n is bits [8n+7:8n]), zero-extended to 32 bits.
- R10: Reads of offset 0x1C and of any undefined offset return 0. Writes to offset 0x00 and to undefined offsets change no state.
- R11: A load write that makes the counter equal to the alarm value sets the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable, one cycle per second |
| addr_i | input | 12 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The bench builds the block with a 32-bit counter and its own identification constant. This lets it compute every identification byte without relying on the design's default. Because the counter width is full size, wraparound is reached by loading a value just below all ones and then giving a few ticks. The same approach exercises an alarm that fires across the wrap from all ones to zero. Simultaneous events are driven in a single cycle: load with tick, and clear with an alarm hit. This confirms the stated priorities.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned RTC_AW = 12;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_MATCH, SEL_LOAD, SEL_CTRL, SEL_MASK,
    SEL_RAW, SEL_MIS, SEL_CLR, SEL_ID, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e rtc_decode(input logic [RTC_AW-1:0] a);
    if (a[RTC_AW-1:5] == '1) return SEL_ID;
    if (a[RTC_AW-1:5] != '0) return SEL_NONE;
    case (a[4:2])
      3'd0:    return SEL_DATA;
      3'd1:    return SEL_MATCH;
      3'd2:    return SEL_LOAD;
      3'd3:    return SEL_CTRL;
      3'd4:    return SEL_MASK;
      3'd5:    return SEL_RAW;
      3'd6:    return SEL_MIS;
      default: return SEL_CLR;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             cnt_upd_o,
  output logic [CNT_W-1:0] last_load_o
);
  logic [CNT_W-1:0] cnt_q, lr_q;

  always_comb begin
    if (load_i)      cnt_nxt_o = load_val_i;
    else if (tick_i) cnt_nxt_o = cnt_q + 1'b1;
    else             cnt_nxt_o = cnt_q;
  end
  assign cnt_upd_o = load_i | tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (load_i) lr_q <= load_val_i;
    end
  end

  assign cnt_o       = cnt_q;
  assign last_load_o = lr_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             cnt_upd_i,
  input  logic             match_we_i,
  input  logic [CNT_W-1:0] match_val_i,
  input  logic             mask_we_i,
  input  logic             mask_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] match_o,
  output logic             raw_o,
  output logic             mask_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] match_q, match_nxt;
  logic raw_q, mask_q, hit;

  assign match_nxt = match_we_i ? match_val_i : match_q;
  // difference of zero (mod 2^CNT_W) on any change of either operand
  assign hit = (match_nxt - cnt_nxt_i == '0) && (cnt_upd_i || match_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      match_q <= match_nxt;
      if (hit)        raw_q <= 1'b1;
      else if (clr_i) raw_q <= 1'b0;
      if (mask_we_i)  mask_q <= mask_val_i;
    end
  end

  assign match_o = match_q;
  assign raw_o   = raw_q;
  assign mask_o  = mask_q;
  assign irq_o   = raw_q & mask_q;
endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DATA_W   = 32,
  parameter logic [63:0] ID_VALUE = 64'hB1_05_F0_0D_00_A3_11_52
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [RTC_AW-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned ID_BYTES = 8;

  reg_sel_e         sel;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, last_load, match_q;
  logic             cnt_upd, raw_q, mask_q;
  logic [7:0]       id_byte [ID_BYTES];

  assign sel = rtc_decode(addr_i);

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .load_i      (wr_i && sel == SEL_LOAD),
    .load_val_i  (wdata_i[CNT_W-1:0]),
    .cnt_o       (cnt_q),
    .cnt_nxt_o   (cnt_nxt),
    .cnt_upd_o   (cnt_upd),
    .last_load_o (last_load)
  );

  rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_nxt_i   (cnt_nxt),
    .cnt_upd_i   (cnt_upd),
    .match_we_i  (wr_i && sel == SEL_MATCH),
    .match_val_i (wdata_i[CNT_W-1:0]),
    .mask_we_i   (wr_i && sel == SEL_MASK),
    .mask_val_i  (wdata_i[0]),
    .clr_i       (wr_i && sel == SEL_CLR),
    .match_o     (match_q),
    .raw_o       (raw_q),
    .mask_o      (mask_q),
    .irq_o       (irq_o)
  );

  for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
    assign id_byte[i] = ID_VALUE[8*i +: 8];
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_DATA:  rdata_o = DATA_W'(cnt_q);
      SEL_MATCH: rdata_o = DATA_W'(match_q);
      SEL_LOAD:  rdata_o = DATA_W'(last_load);
      SEL_CTRL:  rdata_o = DATA_W'(1);
      SEL_MASK:  rdata_o = DATA_W'(mask_q);
      SEL_RAW:   rdata_o = DATA_W'(raw_q);
      SEL_MIS:   rdata_o = DATA_W'(raw_q & mask_q);
      SEL_ID:    rdata_o = DATA_W'(id_byte[addr_i[4:2]]);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_match_timer_chk.sv
module rtc_match_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [11:0]       addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              raw_q
);
  logic load_wr, match_wr, clr_wr;
  assign load_wr  = wr_i && addr_i[11:2] == 10'd2;
  assign match_wr = wr_i && addr_i[11:2] == 10'd1;
  assign clr_wr   = wr_i && addr_i[11:2] == 10'd7;

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> cnt_q == $past(wdata_i[CNT_W-1:0]));
  assert_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_wr) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_wr) |=> $stable(cnt_q));
  assert_match_now_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_wr && !tick_i && wdata_i[CNT_W-1:0] == cnt_q) |=> raw_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !tick_i) |=> !raw_q);
  assert_irq_mis_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[11:2] == 10'd6) |-> rdata_o == DATA_W'(irq_o));
  assert_ctrl_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[11:2] == 10'd3) |-> rdata_o == DATA_W'(1));
  assert_clr_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[11:2] == 10'd7) |-> rdata_o == '0);
endmodule

bind rtc_match_timer rtc_match_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .raw_q   (raw_q)
);

// File: tb/rtc_match_timer_tb_top.sv
module rtc_match_timer_tb_top;
  localparam logic [63:0] TB_ID = 64'h5A_C3_0F_E1_77_20_9B_46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int vectors = 0;
  int miscompares = 0;

  rtc_match_timer #(.CNT_W(32), .DATA_W(32), .ID_VALUE(TB_ID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 count", 12'h000, 0);
    rd_chk("R1 match", 12'h004, 0);
    rd_chk("R1 load", 12'h008, 0);
    rd_chk("R1 mask", 12'h010, 0);
    rd_chk("R1 raw", 12'h014, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_tick;
    ticks(5);
    rd_chk("R2 count after 5 ticks", 12'h000, 5);
    repeat (3) @(negedge clk);
    rd_chk("R2 hold", 12'h000, 5);
  endtask

  task automatic t_load;
    bus_wr(12'h008, 32'h0000_1234);
    rd_chk("R3 count after load", 12'h000, 32'h1234);
    rd_chk("R3 load readback", 12'h008, 32'h1234);
    @(negedge clk); addr = 12'h008; wdata = 32'h0000_0777; wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_chk("R3 load beats tick", 12'h000, 32'h777);
  endtask

  task automatic t_wrap;
    bus_wr(12'h008, 32'hFFFF_FFFE);
    ticks(2);
    rd_chk("R2 wrap to zero", 12'h000, 0);
    ticks(1);
    rd_chk("R2 after wrap", 12'h000, 1);
  endtask

  task automatic t_match_now;
    bus_wr(12'h01C, 0);
    bus_wr(12'h004, 1);
    rd_chk("R4 match readback", 12'h004, 1);
    rd_chk("R4 immediate raw", 12'h014, 1);
    chk("R6 irq masked off", {31'b0, irq}, 0);
    bus_wr(12'h01C, 32'h0000_0000);
    rd_chk("R7 clear with zero data", 12'h014, 0);
  endtask

  task automatic t_match_tick;
    bus_wr(12'h004, 103);
    bus_wr(12'h008, 100);
    bus_wr(12'h01C, 32'hABCD_0000);
    rd_chk("R5 no hit yet", 12'h014, 0);
    ticks(2);
    rd_chk("R5 one short", 12'h014, 0);
    ticks(1);
    rd_chk("R5 hit on tick", 12'h014, 1);
    ticks(2);
    rd_chk("R5 sticky", 12'h014, 1);
    rd_chk("R5 count moved on", 12'h000, 105);
  endtask

  task automatic t_mask;
    bus_wr(12'h010, 32'hFFFF_FFFE);
    rd_chk("R6 mask bit0 only", 12'h010, 0);
    chk("R6 irq low", {31'b0, irq}, 0);
    rd_chk("R6 mis low", 12'h018, 0);
    bus_wr(12'h010, 1);
    chk("R6 irq high", {31'b0, irq}, 1);
    rd_chk("R6 mis high", 12'h018, 1);
    bus_wr(12'h010, 3);
    rd_chk("R6 mask reads 1", 12'h010, 1);
    bus_wr(12'h01C, 32'hFFFF_FFFF);
    chk("R7 irq after clear", {31'b0, irq}, 0);
    rd_chk("R7 mis after clear", 12'h018, 0);
  endtask

  task automatic t_wrap_match;
    bus_wr(12'h004, 1);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h01C, 0);
    ticks(1);
    rd_chk("R5 not at zero", 12'h014, 0);
    ticks(1);
    rd_chk("R5 hit across wrap", 12'h014, 1);
    chk("R6 irq across wrap", {31'b0, irq}, 1);
    bus_wr(12'h01C, 0);
  endtask

  task automatic t_load_hit;
    bus_wr(12'h004, 32'h50);
    bus_wr(12'h01C, 0);
    bus_wr(12'h008, 32'h50);
    rd_chk("R11 load hit", 12'h014, 1);
    bus_wr(12'h01C, 0);
  endtask

  task automatic t_clr_vs_set;
    bus_wr(12'h004, 10);
    bus_wr(12'h008, 9);
    bus_wr(12'h01C, 0);
    @(negedge clk); addr = 12'h01C; wdata = 0; wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_chk("R7 set wins over clear", 12'h014, 1);
    rd_chk("R7 count", 12'h000, 10);
    bus_wr(12'h01C, 0);
  endtask

  task automatic t_ctrl;
    rd_chk("R8 control", 12'h00C, 1);
    bus_wr(12'h00C, 0);
    rd_chk("R8 control after write", 12'h00C, 1);
  endtask

  task automatic t_id;
    for (int i = 0; i < 8; i++)
      rd_chk("R9 id byte", 12'hFE0 + 12'(4 * i), {24'b0, TB_ID[8*i +: 8]});
    rd_chk("R9 id low bits ignored", 12'hFE7, {24'b0, TB_ID[15:8]});
  endtask

  task automatic t_undef;
    rd_chk("R10 clear reads zero", 12'h01C, 0);
    rd_chk("R10 undef 0x020", 12'h020, 0);
    rd_chk("R10 undef 0xFDC", 12'hFDC, 0);
    rd_chk("R10 undef 0x800", 12'h800, 0);
    bus_wr(12'h008, 32'h42);
    bus_wr(12'h000, 32'hDEAD_BEEF);
    bus_wr(12'h024, 32'h1);
    rd_chk("R10 data write ignored", 12'h000, 32'h42);
    rd_chk("R10 match untouched", 12'h004, 10);
    rd_chk("R10 raw untouched", 12'h014, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_tick();
    t_load();
    t_wrap();
    t_match_now();
    t_match_tick();
    t_mask();
    t_wrap_match();
    t_load_hit();
    t_clr_vs_set();
    t_ctrl();
    t_id();
    t_undef();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule